// File: doc/BRIEF.md
# Flash Access Guard

This block sits beside a serial flash sequencer and decides, in the same cycle as each cycle request, whether that request may go ahead. It holds a lower-bound fence register and a small bank of write-protect window registers. Software loads them over a simple register port, reads them back, and then sets a lock that freezes them until the next reset.

Two independent checks combine to drive the block output. The fence refuses every request below its programmed address, reads and writes alike. Each enabled window refuses write-type requests whose page lies inside an inclusive base-to-limit span. Windows are compared at 4 KiB page granularity, so the page number is address bits [23:12].

Top module: `flash_guard`

## Requirements
- R1: After reset the fence reads 0xFF000000, every window register reads 0, locked_o is low, and no request is blocked.
- R2: A write to select 0 stores bits [23:0] of the data as the fence. Bits [31:24] of the fence always read back as 0xFF.
- R3: A valid request whose address is strictly below fence bits [23:0] is blocked, whether it is a read or a write. An address equal to the fence is not blocked by the fence.
- R4: Window register k sits at select k+1 (k = 0..3). Its layout is: enable at bit 31, base page at bits [25:13], limit page at bits [12:0]. All other bits read as 0.
- R5: A valid write request is blocked when some enabled window has base <= address[23:12] <= limit. Both ends of the window are inclusive.
- R6: A window whose enable bit is 0 protects nothing.
- R7: A valid read request (req_write_i low) is not blocked by any window. It is blocked only by the fence.
- R8: block_o is combinational and valid in the same cycle as req_valid_i. It is low whenever req_valid_i is low.
- R9: A high lock_i sets locked_o, which stays high until reset. A register write in the cycle lock_i is high, or in any later cycle, is dropped: read-back and blocking keep the old configuration.
- R10: Selects above 4 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 fence, 1..4 windows |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read-back of the selected register |
| lock_i | input | 1 | Sets the sticky configuration lock |
| locked_o | output | 1 | Lock state |
| req_valid_i | input | 1 | Cycle request strobe |
| req_addr_i | input | 24 | Request flash address |
| req_write_i | input | 1 | Request is a write-type command |
| block_o | output | 1 | Request refused |

## Verification
The vector table holds three kinds of request. Some probe each side of the fence with both command types; these separate the fence, which ignores command type, from the windows, which only refuse writes. Some land on the first page, the last page and the pages just outside each window; these catch off-by-one errors in the inclusive comparisons, including a single-page window. Others fall inside a disabled window that spans the whole address space, or are reads inside enabled windows; these show that the enable bit and the command type both gate the window check. Directed steps then try writes in the lock cycle and after it, and probe unmapped selects, and confirm the old configuration still governs blocking.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int unsigned NUM_WIN    = 4;
  localparam int unsigned ADDR_W     = 24;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned FIELD_W    = 13;
  localparam int unsigned EN_BIT     = 31;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] limit;
  } win_cfg_t;
endpackage

// File: rtl/fg_cfg_decode.sv
module fg_cfg_decode #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               lock_i,
  output logic               fence_we_o,
  output logic [NUM_WIN-1:0] win_we_o,
  output logic               locked_o
);
  logic locked_q;
  logic wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     locked_q <= 1'b0;
    else if (lock_i) locked_q <= 1'b1;
  end

  // a write in the same cycle as the lock request is already refused
  assign wr_ok      = we_i & ~locked_q & ~lock_i;
  assign fence_we_o = wr_ok & (sel_i == '0);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_we
    assign win_we_o[k] = wr_ok & (sel_i == SEL_W'(k + 1));
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/fg_fence.sv
module fg_fence #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              below_o
);
  localparam int unsigned TOP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] bound_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bound_q <= '0;
    else if (we_i) bound_q <= wdata_i[ADDR_W-1:0];
  end

  assign rdata_o = {{TOP_W{1'b1}}, bound_q};
  assign below_o = addr_i < bound_q;
endmodule

// File: rtl/fg_window.sv
module fg_window
  import flash_guard_pkg::*;
#(
  parameter int unsigned PAGE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o
);
  win_cfg_t           cfg_q;
  logic [FIELD_W-1:0] page_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i) begin
      cfg_q.en    <= wdata_i[EN_BIT];
      cfg_q.base  <= wdata_i[2*FIELD_W-1:FIELD_W];
      cfg_q.limit <= wdata_i[FIELD_W-1:0];
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[EN_BIT]              = cfg_q.en;
    rdata_o[2*FIELD_W-1:FIELD_W] = cfg_q.base;
    rdata_o[FIELD_W-1:0]         = cfg_q.limit;
  end

  assign page_x = FIELD_W'(page_i);
  assign hit_o  = cfg_q.en & (page_x >= cfg_q.base) & (page_x <= cfg_q.limit);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  parameter int unsigned SEL_W = $clog2(NUM_WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              lock_i,
  output logic              locked_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              block_o
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

  logic                          fence_we;
  logic [N_WIN-1:0]              win_we;
  logic [DATA_W-1:0]             fence_q;
  logic                          fence_hit;
  logic [N_WIN-1:0]              range_hit;
  logic [N_WIN-1:0][DATA_W-1:0]  win_rd;

  fg_cfg_decode #(.NUM_WIN(N_WIN), .SEL_W(SEL_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .lock_i    (lock_i),
    .fence_we_o(fence_we),
    .win_we_o  (win_we),
    .locked_o  (locked_o)
  );

  fg_fence #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fence (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fence_we),
    .wdata_i(cfg_wdata_i),
    .addr_i (req_addr_i),
    .rdata_o(fence_q),
    .below_o(fence_hit)
  );

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    fg_window #(.PAGE_W(PAGE_W)) u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (win_we[k]),
      .wdata_i(cfg_wdata_i),
      .page_i (req_addr_i[ADDR_W-1:PAGE_SHIFT]),
      .rdata_o(win_rd[k]),
      .hit_o  (range_hit[k])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_sel_i == '0) cfg_rdata_o = fence_q;
    for (int k = 0; k < N_WIN; k++)
      if (cfg_sel_i == SEL_W'(k + 1)) cfg_rdata_o = win_rd[k];
  end

  assign block_o = req_valid_i & (fence_hit | (req_write_i & (|range_hit)));
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
  import flash_guard_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic [ADDR_W-1:0]            req_addr_i,
  input logic                         req_write_i,
  input logic                         block_o,
  input logic                         locked_o,
  input logic [DATA_W-1:0]            fence_q,
  input logic [N_WIN-1:0]             range_hit,
  input logic [N_WIN-1:0][DATA_W-1:0] win_rd
);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !block_o);

  p_fence_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < fence_q[ADDR_W-1:0]) |-> block_o);

  p_read_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i >= fence_q[ADDR_W-1:0]) |-> !block_o);

  p_window_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && (|range_hit)) |-> block_o);

  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  p_lock_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> ($stable(fence_q) && $stable(win_rd)));
endmodule

bind flash_guard flash_guard_chk #(.N_WIN(N_WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_write_i(req_write_i),
  .block_o    (block_o),
  .locked_o   (locked_o),
  .fence_q    (fence_q),
  .range_hit  (range_hit),
  .win_rd     (win_rd)
);

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lock = 1'b0;
  logic        locked;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        blk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .lock_i(lock),
    .locked_o(locked), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .block_o(blk)
  );

  // {addr, write, expected block}
  localparam logic [25:0] VEC [17] = '{
    {24'h00FFFF, 1'b0, 1'b1},  // R3 read below fence
    {24'h00FFFF, 1'b1, 1'b1},  // R3 write below fence
    {24'h010000, 1'b0, 1'b0},  // R3 equal to fence
    {24'h010000, 1'b1, 1'b0},  // R3 equal, no window
    {24'h01FFFF, 1'b1, 1'b0},  // R5 page before window 0
    {24'h020000, 1'b1, 1'b1},  // R5 base edge
    {24'h02FFFF, 1'b1, 1'b1},  // R5 limit edge
    {24'h030000, 1'b1, 1'b0},  // R5 past limit
    {24'h025000, 1'b0, 1'b0},  // R7 read inside window
    {24'h100000, 1'b1, 1'b1},  // R5 single page window
    {24'h100FFF, 1'b1, 1'b1},  // R5 single page, last byte
    {24'h101000, 1'b1, 1'b0},  // R5 after single page
    {24'h0FF000, 1'b1, 1'b0},  // R5 before single page
    {24'h500000, 1'b1, 1'b0},  // R6 only disabled window covers it
    {24'h880000, 1'b1, 1'b1},  // R5 window 3
    {24'h880000, 1'b0, 1'b0},  // R7 read in window 3
    {24'hFFFFFF, 1'b1, 1'b0}   // R6 top of space
  };

  function automatic logic [31:0] mk_win(bit en, logic [12:0] base, logic [12:0] lim);
    return {en, 5'b0, base, lim};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] data, bit with_lock);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data; lock = with_lock;
    @(negedge clk);
    cfg_we = 1'b0; lock = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] sel, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic req_check(string req, logic [23:0] a, bit w, bit v, bit exp);
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    #1 check(req, {31'b0, blk}, {31'b0, exp});
    req_valid = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check("R1 fence", 3'd0, 32'hFF000000);
    for (int k = 1; k <= 4; k++) rd_check("R1 window", 3'(k), 32'h0);
    check("R1 locked", {31'b0, locked}, 32'h0);
    req_check("R1 no block", 24'h000000, 1'b1, 1'b1, 1'b0);

    // R2 fence write, top byte forced
    wr(3'd0, 32'hAB010000, 1'b0);
    rd_check("R2 fence", 3'd0, 32'hFF010000);

    // R4 window layout
    wr(3'd1, mk_win(1'b1, 13'h020, 13'h02F), 1'b0);
    wr(3'd2, mk_win(1'b1, 13'h100, 13'h100), 1'b0);
    wr(3'd3, 32'h4000_0FFF, 1'b0);  // disabled, spans all pages, stray bit 30
    wr(3'd4, mk_win(1'b1, 13'h800, 13'h900), 1'b0);
    rd_check("R4 win0", 3'd1, mk_win(1'b1, 13'h020, 13'h02F));
    rd_check("R4 win2 masked", 3'd3, 32'h0000_0FFF);
    rd_check("R4 win3", 3'd4, mk_win(1'b1, 13'h800, 13'h900));

    // R10 unmapped selects
    wr(3'd5, 32'hFFFF_FFFF, 1'b0);
    rd_check("R10 sel5", 3'd5, 32'h0);
    rd_check("R10 sel7", 3'd7, 32'h0);
    rd_check("R10 fence kept", 3'd0, 32'hFF010000);

    // table of requests (R3 R5 R6 R7)
    for (int i = 0; i < 17; i++)
      req_check($sformatf("R3/R5/R6/R7 vector %0d", i),
                VEC[i][25:2], VEC[i][1], 1'b1, VEC[i][0]);

    // R8 idle request never blocks
    req_check("R8 idle", 24'h000000, 1'b1, 1'b0, 1'b0);

    // R9 write in lock cycle dropped, later writes dropped
    wr(3'd0, 32'h00FFFFFF, 1'b1);
    check("R9 locked", {31'b0, locked}, 32'h1);
    rd_check("R9 fence kept", 3'd0, 32'hFF010000);
    wr(3'd1, 32'h0, 1'b0);
    rd_check("R9 window kept", 3'd1, mk_win(1'b1, 13'h020, 13'h02F));
    req_check("R9 still blocks", 24'h020000, 1'b1, 1'b1, 1'b1);
    req_check("R9 fence unchanged", 24'h100FFF, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 lock sticky", {31'b0, locked}, 32'h1);

    // R1 reset clears lock and config
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 lock cleared", {31'b0, locked}, 32'h0);
    rd_check("R1 fence after reset", 3'd0, 32'hFF000000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule